// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block carries out one block load or block store of up to sixteen registers. A command carries the low 25 bits of the instruction word, the base register value, the address of the instruction itself and the current processor mode. The sequencer walks the 16-bit register list and makes one 32-bit memory access per set bit. On a load it issues register writes, and on a store it reads registers through a read port. When the transfer is complete it reports a base writeback, and for the privileged variant it raises a status-restore request.

The command port uses a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The memory port is a request with back-pressure: `mem_req_valid` stays high, and address, direction and write data stay unchanged, until the cycle in which `mem_ready` is high. That cycle completes the access, and load data is taken from `mem_rdata` in that same cycle. The register read port is combinational: `rd_data` must answer `rd_idx`/`rd_user` in the same cycle.

Top module: `lsm_sequencer`

## Requirements
- R1: Field positions in `cmd_instr`:
  - bit 24: pre-index.
  - bit 23: up.
  - bit 22: S.
  - bit 21: writeback.
  - bit 20: load (1) or store (0).
  - bits 19:16: base register index.
  - bits 15:0: register list.
  
  `cmd_ready` is 1 only in idle. `mem_we` is the inverse of the load bit.
- R2: With up set, registers are transferred in ascending index order. The first address is base plus 4 if pre-index is set, otherwise the base, and each later access adds 4.
- R3: With up clear, registers are transferred in descending index order. The first address is base minus 4 if pre-index is set, otherwise the base, and each later access subtracts 4.
- R4: The base writeback happens when pre-index is clear, or when pre-index and writeback are both set.
  - With up set, it writes the address that follows the last access.
  - With up clear, it writes that address plus 4.
  - `wb_idx` is bits 19:16.
- R5: A store of register 15 writes the instruction address plus 12.
- R6: A load of register 15 writes the loaded word with bits 1:0 cleared. Other registers receive the loaded word unchanged.
- R7: On a load with S set and register 15 in the list, `psr_restore` pulses in the same cycle as the register 15 write, and at no other time.
- R8: On a load with S set and register 15 absent, every write has `wr_user` = 1 when the mode is privileged. A mode is privileged when it is neither 0x10 (user) nor 0x1F (system). In every other case `wr_user` = 0.
- R9: On a store with S set in a privileged mode, every access reads with `rd_user` = 1, whether or not register 15 is in the list. Otherwise `rd_user` = 0.
- R10: A pending memory request holds its address, direction and write data stable until `mem_ready` is seen.
- R11: `done` is high for exactly one cycle, in the cycle after the last completed access. `wb_en` is asserted only in that cycle.
- R12: An empty register list gives `done` in the cycle after acceptance, with no memory request and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_instr | input | 25 | Low bits of the instruction word |
| cmd_base | input | 32 | Base register value |
| cmd_pc | input | 32 | Address of the instruction |
| cmd_mode | input | 5 | Current processor mode |
| mem_req_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_addr | output | 32 | Access address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rd_idx | output | 4 | Register read index |
| rd_user | output | 1 | Read from user bank |
| rd_data | input | 32 | Register read data |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 4 | Register write index |
| wr_user | output | 1 | Write goes to user bank |
| wr_data | output | 32 | Register write data |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | New base value |
| psr_restore | output | 1 | Copy saved status into current status |
| done | output | 1 | Transfer complete |

## Verification
Two coincidences matter most. A privileged load that includes register 15 must raise the PC write and the status restore on the same cycle. The final memory handshake must be followed, on exactly the next cycle, by `done` together with the base writeback. A sweep covers every combination of the five control bits, eight register lists (empty, single low, single PC, full, sparse, and lists with and without register 15) and both a user and a privileged mode, while the memory stalls at irregular intervals. Every sampled cycle is compared against an address, index and data sequence the bench computes arithmetically. A status restore on any cycle other than the PC write fails, and so does a `done` cycle that is not the one right after the last handshake.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;
  localparam int NREG    = 16;
  localparam int IDX_W   = $clog2(NREG);
  localparam int INSTR_W = 25;

  // control field positions within the instruction word
  localparam int BIT_PRE  = 24;
  localparam int BIT_UP   = 23;
  localparam int BIT_SBIT = 22;
  localparam int BIT_WBK  = 21;
  localparam int BIT_LOAD = 20;
  localparam int RN_LSB   = 16;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} lsm_state_e;

  typedef struct packed {
    logic             pre;
    logic             up;
    logic             sbit;
    logic             wbk;
    logic             load;
    logic             has_pc;
    logic             banked;
    logic [IDX_W-1:0] rn;
    logic [NREG-1:0]  list;
  } lsm_ctl_t;
endpackage

// File: rtl/lsm_decode.sv
`timescale 1ns/1ps
module lsm_decode
  import lsm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  base,
  input  logic [4:0]         mode,
  output lsm_ctl_t           ctl,
  output logic [DATA_W-1:0]  first_addr
);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  always_comb begin
    ctl.pre    = instr[BIT_PRE];
    ctl.up     = instr[BIT_UP];
    ctl.sbit   = instr[BIT_SBIT];
    ctl.wbk    = instr[BIT_WBK];
    ctl.load   = instr[BIT_LOAD];
    ctl.rn     = instr[RN_LSB +: IDX_W];
    ctl.list   = instr[NREG-1:0];
    ctl.has_pc = instr[NREG-1];
    // user and system modes share the user bank, all others own banks
    ctl.banked = (mode != MODE_USR) && (mode != MODE_SYS);
  end

  always_comb begin
    if (instr[BIT_UP])
      first_addr = instr[BIT_PRE] ? base + STEP_V : base;
    else
      first_addr = instr[BIT_PRE] ? base - STEP_V : base;
  end
endmodule

// File: rtl/lsm_list_scan.sv
`timescale 1ns/1ps
module lsm_list_scan
  import lsm_pkg::*;
(
  input  logic [NREG-1:0]  mask,
  input  logic             up,
  output logic [IDX_W-1:0] idx,
  output logic             found,
  output logic             last
);
  localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

  // ascending walk takes the lowest set bit, descending the highest
  always_comb begin
    idx   = '0;
    found = 1'b0;
    if (up) begin
      for (int i = NREG - 1; i >= 0; i--) begin
        if (mask[i]) begin
          idx   = IDX_W'(i);
          found = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (mask[i]) begin
          idx   = IDX_W'(i);
          found = 1'b1;
        end
      end
    end
  end

  assign last = found && ((mask & ~(ONE << idx)) == '0);
endmodule

// File: rtl/lsm_addr_gen.sv
`timescale 1ns/1ps
module lsm_addr_gen #(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              up,
  input  logic [DATA_W-1:0] first,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wb_val
);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= first;
    else if (advance) addr <= up ? addr + STEP_V : addr - STEP_V;
  end

  // after the walk the register already points one step past the last access
  assign wb_val = up ? addr : addr + STEP_V;
endmodule

// File: rtl/lsm_sequencer.sv
`timescale 1ns/1ps
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4,
  parameter int PC_ADJ = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [INSTR_W-1:0] cmd_instr,
  input  logic [DATA_W-1:0] cmd_base,
  input  logic [DATA_W-1:0] cmd_pc,
  input  logic [4:0]        cmd_mode,
  output logic              mem_req_valid,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_user,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_user,
  output logic [DATA_W-1:0] wr_data,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              psr_restore,
  output logic              done
);
  localparam logic [DATA_W-1:0] PC_ADJ_V = DATA_W'(PC_ADJ);
  localparam logic [DATA_W-1:0] PC_MASK  = ~DATA_W'(3);
  localparam logic [IDX_W-1:0]  PC_IDX   = IDX_W'(NREG - 1);

  lsm_state_e        state_q;
  lsm_ctl_t          ctl_q;
  lsm_ctl_t          dec_ctl;
  logic [NREG-1:0]   mask_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] dec_first;
  logic [DATA_W-1:0] addr;
  logic [DATA_W-1:0] wb_val;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_found;
  logic              cur_last;
  logic              accept;
  logic              xfer;
  logic              hs;
  logic              is_pc;

  lsm_decode #(.DATA_W(DATA_W), .STEP(STEP)) u_dec (
    .instr      (cmd_instr),
    .base       (cmd_base),
    .mode       (cmd_mode),
    .ctl        (dec_ctl),
    .first_addr (dec_first)
  );

  lsm_list_scan u_scan (
    .mask  (mask_q),
    .up    (ctl_q.up),
    .idx   (cur_idx),
    .found (cur_found),
    .last  (cur_last)
  );

  lsm_addr_gen #(.DATA_W(DATA_W), .STEP(STEP)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .advance (hs),
    .up      (ctl_q.up),
    .first   (dec_first),
    .addr    (addr),
    .wb_val  (wb_val)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign xfer      = (state_q == ST_XFER) && cur_found;
  assign hs        = xfer && mem_ready;
  assign is_pc     = (cur_idx == PC_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      mask_q  <= '0;
      pc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            ctl_q   <= dec_ctl;
            mask_q  <= dec_ctl.list;
            pc_q    <= cmd_pc;
            state_q <= (dec_ctl.list == '0) ? ST_FIN : ST_XFER;
          end
        end
        ST_XFER: begin
          if (hs) begin
            mask_q[cur_idx] <= 1'b0;
            if (cur_last) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // memory side
  assign mem_req_valid = xfer;
  assign mem_addr      = addr;
  assign mem_we        = !ctl_q.load;
  assign mem_wdata     = is_pc ? pc_q + PC_ADJ_V : rd_data;

  // register read side (stores)
  assign rd_idx  = cur_idx;
  assign rd_user = xfer && !ctl_q.load && ctl_q.sbit && ctl_q.banked;

  // register write side (loads)
  assign wr_en       = hs && ctl_q.load;
  assign wr_idx      = cur_idx;
  assign wr_data     = is_pc ? (mem_rdata & PC_MASK) : mem_rdata;
  assign wr_user     = wr_en && ctl_q.sbit && !ctl_q.has_pc && ctl_q.banked;
  assign psr_restore = wr_en && ctl_q.sbit && is_pc;

  // completion
  assign done    = (state_q == ST_FIN);
  assign wb_en   = done && (ctl_q.list != '0) && (!ctl_q.pre || ctl_q.wbk);
  assign wb_idx  = ctl_q.rn;
  assign wb_data = wb_val;
endmodule

// File: rtl/lsm_sequencer_chk.sv
`timescale 1ns/1ps
module lsm_sequencer_chk
  import lsm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rd_user,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              wr_user,
  input logic [DATA_W-1:0] wr_data,
  input logic              wb_en,
  input logic              psr_restore,
  input logic              done
);
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);
  localparam logic [IDX_W-1:0]  PC_IDX = IDX_W'(NREG - 1);

  // R1
  accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !done);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_ready |=>
      (!mem_req_valid || mem_addr == $past(mem_addr) + STEP_V
                      || mem_addr == $past(mem_addr) - STEP_V));

  // R6
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == PC_IDX |-> wr_data[1:0] == 2'b00);

  // R7
  psr_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> wr_en && wr_idx == PC_IDX);

  // R8
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_user |-> wr_en && !psr_restore);

  // R9
  user_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_user |-> mem_req_valid && mem_we);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_ready |=>
      mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !mem_req_valid);
endmodule

bind lsm_sequencer lsm_sequencer_chk #(.DATA_W(DATA_W), .STEP(STEP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_we        (mem_we),
  .mem_wdata     (mem_wdata),
  .rd_user       (rd_user),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_user       (wr_user),
  .wr_data       (wr_data),
  .wb_en         (wb_en),
  .psr_restore   (psr_restore),
  .done          (done)
);

// File: tb/lsm_sequencer_test.sv
`timescale 1ns/1ps
module lsm_sequencer_test;
  import lsm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [24:0] cmd_instr = '0;
  logic [31:0] cmd_base = '0;
  logic [31:0] cmd_pc = '0;
  logic [4:0]  cmd_mode = 5'h10;
  logic        mem_req_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic [3:0]  rd_idx;
  logic        rd_user;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic        wr_user;
  logic [31:0] wr_data;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;
  logic        psr_restore;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [7:0] lfsr = 8'h5D;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] regval(input logic [3:0] idx, input logic usr);
    return (usr ? 32'hB000_0000 : 32'hA000_0000) | ({28'd0, idx} * 32'h0101_0011);
  endfunction

  function automatic logic [31:0] memval(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  always_comb rd_data   = regval(rd_idx, rd_user);
  always_comb mem_rdata = memval(mem_addr);

  lsm_sequencer uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] list, input logic [4:0] fl, input logic [4:0] mode,
                     input logic [3:0] rn, input logic [31:0] base, input logic [31:0] pc);
    int seq[16];
    int n;
    int k;
    int cyc;
    bit p, u, s, w, l, banked, prev_hs, fin;
    logic [31:0] a;
    logic [31:0] expv;
    logic [3:0] idx;
    p = fl[4]; u = fl[3]; s = fl[2]; w = fl[1]; l = fl[0];
    banked = (mode != 5'h10) && (mode != 5'h1F);
    n = 0;
    if (u) begin
      for (int i = 0; i < 16; i++) if (list[i]) begin seq[n] = i; n++; end
    end else begin
      for (int i = 15; i >= 0; i--) if (list[i]) begin seq[n] = i; n++; end
    end
    a = u ? base + (p ? 32'd4 : 32'd0) : base - (p ? 32'd4 : 32'd0);

    @(negedge clk);
    cmd_instr = {p, u, s, w, l, rn, list};
    cmd_base = base; cmd_pc = pc; cmd_mode = mode; cmd_valid = 1'b1;
    #1;
    chk(cmd_ready === 1'b1, "R1 ready in idle", {31'd0, cmd_ready}, 32'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;

    k = 0; cyc = 0; prev_hs = 1'b1; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[1];
      #1;
      cyc++;
      if (done) begin
        // R11 done right after the last handshake, R12 for empty list
        chk(k == n, (n == 0) ? "R12 transfer count" : "R11 transfer count", k, n);
        chk(prev_hs, (n == 0) ? "R12 done next cycle" : "R11 done after last access", {31'd0, prev_hs}, 32'd1);
        chk(mem_req_valid === 1'b0, "R11 no request with done", {31'd0, mem_req_valid}, 32'd0);
        chk(wb_en === ((n != 0) && (!p || w)), (n == 0) ? "R12 no writeback" : "R4 writeback enable",
            {31'd0, wb_en}, {31'd0, (n != 0) && (!p || w)});
        if (n != 0 && (!p || w)) begin
          expv = u ? a : a + 32'd4;
          chk(wb_data === expv, "R4 writeback value", wb_data, expv);
          chk(wb_idx === rn, "R4 writeback index", {28'd0, wb_idx}, {28'd0, rn});
        end
        fin = 1'b1;
      end else if (mem_req_valid) begin
        chk(k < n, "R11 extra access", k, n);
        chk(mem_addr === a, u ? "R2 address" : "R3 address", mem_addr, a);
        chk(mem_we === !l, "R1 direction", {31'd0, mem_we}, {31'd0, !l});
        prev_hs = mem_ready;
        if (mem_ready && k < n) begin
          idx = 4'(seq[k]);
          if (!l) begin
            chk(rd_user === (s && banked), "R9 user-bank read", {31'd0, rd_user}, {31'd0, s && banked});
            expv = (idx == 4'd15) ? pc + 32'd12 : regval(idx, s && banked);
            chk(mem_wdata === expv, (idx == 4'd15) ? "R5 stored PC" : "R9 store data", mem_wdata, expv);
            chk(wr_en === 1'b0, "R1 no write on store", {31'd0, wr_en}, 32'd0);
          end else begin
            chk(wr_en === 1'b1 && wr_idx === idx, u ? "R2 load order" : "R3 load order",
                {27'd0, wr_en, wr_idx}, {27'd0, 1'b1, idx});
            expv = (idx == 4'd15) ? (memval(a) & 32'hFFFF_FFFC) : memval(a);
            chk(wr_data === expv, "R6 load data", wr_data, expv);
            chk(wr_user === (s && !list[15] && banked), "R8 user-bank write",
                {31'd0, wr_user}, {31'd0, s && !list[15] && banked});
            chk(psr_restore === (s && idx == 4'd15), "R7 status restore",
                {31'd0, psr_restore}, {31'd0, s && idx == 4'd15});
          end
          a = u ? a + 32'd4 : a - 32'd4;
          k++;
        end else begin
          chk(wr_en === 1'b0 && psr_restore === 1'b0, "R10 nothing during stall",
              {30'd0, wr_en, psr_restore}, 32'd0);
        end
      end else begin
        chk(1'b0, "R11 idle gap before done", {31'd0, mem_req_valid}, 32'd1);
        prev_hs = 1'b0;
      end
      if (cyc > 300 && !fin) begin
        chk(1'b0, "R11 run timeout", cyc, 300);
        fin = 1'b1;
      end
    end
    @(negedge clk); #1;
    chk(done === 1'b0 && cmd_ready === 1'b1, "R11 single done pulse",
        {30'd0, done, cmd_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] lists[8];
    int r;
    lists = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h8421, 16'h7FFE, 16'h1248, 16'h8001};
    repeat (3) @(posedge clk);
    #1;
    // R1, R11 reset state
    chk(cmd_ready === 1'b1, "R1 reset ready", {31'd0, cmd_ready}, 32'd1);
    chk(done === 1'b0 && mem_req_valid === 1'b0 && wr_en === 1'b0 && wb_en === 1'b0,
        "R11 reset outputs quiet", {28'd0, done, mem_req_valid, wr_en, wb_en}, 32'd0);
    rst_n = 1'b1;
    r = 0;
    for (int li = 0; li < 8; li++) begin
      for (int f = 0; f < 32; f++) begin
        for (int m = 0; m < 2; m++) begin
          run(lists[li], 5'(f), (m == 0) ? 5'h10 : 5'h13, 4'(r % 16),
              32'h0000_4000 + 32'(r * 64), 32'h0000_8000 + 32'(r * 4));
          r++;
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule